// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block gives host software a guarded window into a chip's configuration registers over a narrow I/O bus. Two byte-wide locations are used: an index port, which is write-only, and a data port one address above it. The window stays shut until software writes the enter key (83h) to the index port twice in a row. After that, a byte written to the index port picks a register and the data port reads or writes it. Writing the exit key (AAh) to the index port shuts the window again.

The register space has two halves. Indices below 30h are global: a software-reset strobe, the logical-device selector, a read-only identity pair, interface power enables, wake-event enables, and a control byte. The control byte moves the port pair between its two base addresses and can lock the whole port until the next hardware reset. Indices 30h and above are banked. The selector at 07h chooses which device's copy of these registers the port reaches. Every register value is exported on ports for the neighbouring blocks.

The key logic is a four-state machine (`KS_IDLE`, `KS_HALF`, `KS_OPEN`, `KS_LOCKED`) with these transitions:
- idle-to-half on one enter key;
- half-to-open on a second enter key;
- half-to-idle on any other index write;
- open-to-idle on the exit key;
- open-to-locked on a lock write.

Top module: `cfg_port`

## Requirements
- R1: After hardware reset: `cfg_mode`=0, `cfg_locked`=0, `port_sel`=0, `ldev_num`=00h, `pwr_on`=3'b100 (power register reads 80h), `pme_en`=0, and every banked export is 0.
- R2: Two consecutive writes of 83h to the index port raise `cfg_mode` in the cycle after the second write. A single 83h does not.
- R3: Outside configuration mode, an index-port write of any value other than 83h that follows one 83h discards the half-entered key. Two fresh 83h writes are then needed.
- R4: Writing AAh to the index port in configuration mode clears `cfg_mode`.
- R5: Outside configuration mode, data-port reads return FFh and data-port writes change no register.
- R6: Control register 26h bit 6 selects the port pair: 0 gives index 2Eh and data 2Fh, 1 gives index 4Eh and data 4Fh. The unselected pair is ignored. The new pair applies from the next access.
- R7: Index 20h reads 71h. Index 21h reads {2h, REV}, with REV=0 by default.
- R8: Index 07h holds the device selector. Indices of 30h and above reach the selected device's bank:
  - 30h bit 0 is the active flag;
  - 60h and 61h are the high and low base bytes;
  - 70h[3:0] is the interrupt choice;
  - 74h[3:0] is the request choice;
  - F0h bit 0 is an option flag;
  - unused bits read 0;
  - a selector of NDEV or more reads 00h and writes nothing.
- R9: Global indices work whatever the selector holds. 22h[7:5] drives `pwr_on[2:0]`, 23h[7:4] drives `pme_en[3:0]`, and their other bits read 0.
- R10: Writing 02h with bit 0 set gives a one-cycle `soft_rst` pulse in the next cycle. Index 02h reads 00h.
- R11: Writing 26h with bit 5 set raises `cfg_locked` and clears `cfg_mode`. Keys are then ignored and the port stays shut until hardware reset.
- R12: Reading the index port returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_stb | input | 1 | Decoded I/O write strobe, one cycle per access |
| rd_stb | input | 1 | Decoded I/O read strobe |
| addr | input | 10 | I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, FFh when no register is read |
| cfg_mode | output | 1 | Configuration window open |
| cfg_locked | output | 1 | Port locked until hardware reset |
| soft_rst | output | 1 | One-cycle software reset pulse |
| ldev_num | output | 8 | Device selector |
| pwr_on | output | 3 | Interface power enables (1 = powered) |
| pme_en | output | 4 | Wake-event enable bits |
| port_sel | output | 1 | Port pair select (0: 2Eh/2Fh, 1: 4Eh/4Fh) |
| dev_active | output | NDEV | Per-device active flags |
| dev_base | output | NDEV*16 | Per-device base address, device i at [16i+15:16i] |
| dev_irq | output | NDEV*4 | Per-device interrupt choice |
| dev_drq | output | NDEV*4 | Per-device request choice |
| dev_opt | output | NDEV | Per-device option flag |

## Verification
A single write to control register 26h can move the port pair and lock the port in the same cycle. The bench writes 60h there and then judges the result at both address pairs:
- `port_sel` must follow the write;
- `cfg_locked` must rise while `cfg_mode` falls;
- enter keys at either pair must leave the window shut;
- data reads must return FFh.

Only a hardware reset may clear the lock and restore the 2Eh pair.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2,
        KS_LOCKED = 2'd3
    } key_state_e;

    localparam logic [7:0] KEY_ENTER   = 8'h83;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] IX_SRST     = 8'h02;
    localparam logic [7:0] IX_LDN      = 8'h07;
    localparam logic [7:0] IX_ID_HI    = 8'h20;
    localparam logic [7:0] IX_ID_LO    = 8'h21;
    localparam logic [7:0] IX_PWR      = 8'h22;
    localparam logic [7:0] IX_PME      = 8'h23;
    localparam logic [7:0] IX_CTRL     = 8'h26;
    localparam logic [7:0] IX_BANK_MIN = 8'h30;
    localparam logic [7:0] IX_ACT      = 8'h30;
    localparam logic [7:0] IX_BASE_HI  = 8'h60;
    localparam logic [7:0] IX_BASE_LO  = 8'h61;
    localparam logic [7:0] IX_IRQ      = 8'h70;
    localparam logic [7:0] IX_DRQ      = 8'h74;
    localparam logic [7:0] IX_OPT      = 8'hF0;
    localparam logic [7:0] ID_HI_VAL   = 8'h71;
    localparam logic [3:0] ID_LO_TOP   = 4'h2;
    localparam logic [2:0] PWR_RESET   = 3'b100;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       lock_req,
    output key_state_e state,
    output logic       open,
    output logic       locked,
    output logic [7:0] index
);
    key_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            KS_IDLE:   if (idx_wr && wdata == KEY_ENTER) nxt = KS_HALF;
            KS_HALF:   if (idx_wr) nxt = (wdata == KEY_ENTER) ? KS_OPEN : KS_IDLE;
            KS_OPEN: begin
                if (lock_req)                         nxt = KS_LOCKED;
                else if (idx_wr && wdata == KEY_EXIT) nxt = KS_IDLE;
            end
            KS_LOCKED: nxt = KS_LOCKED;
        endcase
    end

    always_comb begin
        open   = (state == KS_OPEN);
        locked = (state == KS_LOCKED);
    end

    // index register only moves while the window is open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            index <= 8'h00;
        else if (open && idx_wr && wdata != KEY_EXIT)
            index <= wdata;
    end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
    import cfg_pkg::*;
#(
    parameter logic [3:0] REV = 4'h0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] rd_val,
    output logic       lock_req,
    output logic       soft_rst,
    output logic [7:0] ldn,
    output logic [2:0] pwr_on,
    output logic [3:0] pme_en,
    output logic       port_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
            ldn      <= 8'h00;
            pwr_on   <= PWR_RESET;
            pme_en   <= 4'h0;
            port_sel <= 1'b0;
        end else begin
            soft_rst <= wr_en && (index == IX_SRST) && wdata[0];
            if (wr_en) begin
                case (index)
                    IX_LDN:  ldn      <= wdata;
                    IX_PWR:  pwr_on   <= wdata[7:5];
                    IX_PME:  pme_en   <= wdata[7:4];
                    IX_CTRL: port_sel <= wdata[6];
                    default: ;
                endcase
            end
        end
    end

    assign lock_req = wr_en && (index == IX_CTRL) && wdata[5];

    always_comb begin
        case (index)
            IX_LDN:   rd_val = ldn;
            IX_ID_HI: rd_val = ID_HI_VAL;
            IX_ID_LO: rd_val = {ID_LO_TOP, REV};
            IX_PWR:   rd_val = {pwr_on, 5'b0};
            IX_PME:   rd_val = {pme_en, 4'b0};
            IX_CTRL:  rd_val = {1'b0, port_sel, 6'b0};
            default:  rd_val = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        sel,
    input  logic [7:0]  index,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_val,
    output logic        active,
    output logic [15:0] base,
    output logic [3:0]  irq,
    output logic [3:0]  drq,
    output logic        opt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= 16'h0000;
            irq    <= 4'h0;
            drq    <= 4'h0;
            opt    <= 1'b0;
        end else if (wr_en && sel) begin
            case (index)
                IX_ACT:     active      <= wdata[0];
                IX_BASE_HI: base[15:8]  <= wdata;
                IX_BASE_LO: base[7:0]   <= wdata;
                IX_IRQ:     irq         <= wdata[3:0];
                IX_DRQ:     drq         <= wdata[3:0];
                IX_OPT:     opt         <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (index)
            IX_ACT:     rd_val = {7'b0, active};
            IX_BASE_HI: rd_val = base[15:8];
            IX_BASE_LO: rd_val = base[7:0];
            IX_IRQ:     rd_val = {4'b0, irq};
            IX_DRQ:     rd_val = {4'b0, drq};
            IX_OPT:     rd_val = {7'b0, opt};
            default:    rd_val = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_pkg::*;
#(
    parameter int                NDEV   = 3,
    parameter int                ADDR_W = 10,
    parameter logic [ADDR_W-1:0] PORT_A = 10'h02E,
    parameter logic [ADDR_W-1:0] PORT_B = 10'h04E,
    parameter logic [3:0]        REV    = 4'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 cfg_mode,
    output logic                 cfg_locked,
    output logic                 soft_rst,
    output logic [7:0]           ldev_num,
    output logic [2:0]           pwr_on,
    output logic [3:0]           pme_en,
    output logic                 port_sel,
    output logic [NDEV-1:0]      dev_active,
    output logic [NDEV*16-1:0]   dev_base,
    output logic [NDEV*4-1:0]    dev_irq,
    output logic [NDEV*4-1:0]    dev_drq,
    output logic [NDEV-1:0]      dev_opt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] idx_port, dat_port;
    logic              idx_wr, dat_wr, dat_rd, cfg_wr;
    logic              lock_req;
    logic [7:0]        index, glob_rd, bank_val, cfg_val;
    logic [7:0]        bank_rd [NDEV];
    key_state_e        key_state;

    assign idx_port = port_sel ? PORT_B : PORT_A;
    assign dat_port = idx_port + ONE;
    assign idx_wr   = wr_stb && (addr == idx_port);
    assign dat_wr   = wr_stb && (addr == dat_port);
    assign dat_rd   = rd_stb && (addr == dat_port);
    assign cfg_wr   = dat_wr && cfg_mode;

    cfg_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (wdata),
        .lock_req (lock_req),
        .state    (key_state),
        .open     (cfg_mode),
        .locked   (cfg_locked),
        .index    (index)
    );

    cfg_global_regs #(.REV(REV)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr && index < IX_BANK_MIN),
        .index    (index),
        .wdata    (wdata),
        .rd_val   (glob_rd),
        .lock_req (lock_req),
        .soft_rst (soft_rst),
        .ldn      (ldev_num),
        .pwr_on   (pwr_on),
        .pme_en   (pme_en),
        .port_sel (port_sel)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        cfg_dev_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_wr && index >= IX_BANK_MIN),
            .sel    (ldev_num == 8'(g)),
            .index  (index),
            .wdata  (wdata),
            .rd_val (bank_rd[g]),
            .active (dev_active[g]),
            .base   (dev_base[g*16 +: 16]),
            .irq    (dev_irq[g*4 +: 4]),
            .drq    (dev_drq[g*4 +: 4]),
            .opt    (dev_opt[g])
        );
    end

    always_comb begin
        bank_val = 8'h00;
        for (int i = 0; i < NDEV; i++)
            if (ldev_num == 8'(i)) bank_val = bank_rd[i];
        cfg_val = (index < IX_BANK_MIN) ? glob_rd : bank_val;
        rdata   = (dat_rd && cfg_mode) ? cfg_val : 8'hFF;
    end

    logic unused_ok;
    assign unused_ok = ^key_state;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       cfg_mode,
    input logic       cfg_locked,
    input logic       soft_rst,
    input logic [7:0] ldev_num,
    input logic [2:0] pwr_on,
    input logic       port_sel
);
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(wr_stb && wdata == 8'h83));

    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    a_r11_lock_shut: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |-> !cfg_mode);

    a_r10_srst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    a_r5_closed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> rdata == 8'hFF);

    a_r5_closed_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_mode) |-> ($stable(ldev_num) && $stable(pwr_on) && $stable(port_sel)));
endmodule

bind cfg_port cfg_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wdata      (wdata),
    .rdata      (rdata),
    .cfg_mode   (cfg_mode),
    .cfg_locked (cfg_locked),
    .soft_rst   (soft_rst),
    .ldev_num   (ldev_num),
    .pwr_on     (pwr_on),
    .port_sel   (port_sel)
);

// File: tb/cfg_port_tb.sv
module cfg_port_tb;
    localparam int NDEV = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_stb = 1'b0, rd_stb = 1'b0;
    logic [9:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             cfg_mode, cfg_locked, soft_rst, port_sel;
    logic [7:0]       ldev_num;
    logic [2:0]       pwr_on;
    logic [3:0]       pme_en;
    logic [NDEV-1:0]  dev_active, dev_opt;
    logic [NDEV*16-1:0] dev_base;
    logic [NDEV*4-1:0]  dev_irq, dev_drq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    cfg_port #(.NDEV(NDEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cfg_mode(cfg_mode), .cfg_locked(cfg_locked), .soft_rst(soft_rst),
        .ldev_num(ldev_num), .pwr_on(pwr_on), .pme_en(pme_en),
        .port_sel(port_sel), .dev_active(dev_active), .dev_base(dev_base),
        .dev_irq(dev_irq), .dev_drq(dev_drq), .dev_opt(dev_opt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // driver: pushes expected read data, monitor compares
    task automatic rd(input logic [9:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        x.v = e; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic enter(input logic [9:0] p);
        wr(p, 8'h83); wr(p, 8'h83);
    endtask

    task automatic setr(input logic [9:0] p, input logic [7:0] ix, input logic [7:0] d);
        wr(p, ix); wr(p + 10'd1, d);
    endtask

    task automatic getr(input logic [9:0] p, input logic [7:0] ix, input logic [7:0] e, input string tag);
        wr(p, ix); rd(p + 10'd1, e, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rd_stb) begin
                if (q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL monitor: read with no expected item, actual %0h expected none", rdata);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    check(x.tag, 32'(rdata), 32'(x.v));
                end
            end
        end
    end

    task automatic reset_checks(input string tag);
        check({tag, " cfg_mode"}, 32'(cfg_mode), 0);
        check({tag, " locked"}, 32'(cfg_locked), 0);
        check({tag, " port_sel"}, 32'(port_sel), 0);
        check({tag, " ldev"}, 32'(ldev_num), 0);
        check({tag, " pwr_on"}, 32'(pwr_on), 32'b100);
        check({tag, " pme_en"}, 32'(pme_en), 0);
        check({tag, " active"}, 32'(dev_active), 0);
        check({tag, " base"}, 32'(dev_base[31:0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("R1");

        // R5: closed port
        rd(10'h02F, 8'hFF, "R5 closed read");
        enter(10'h02E);
        setr(10'h02E, 8'h07, 8'h00);
        wr(10'h02E, 8'hAA);
        wr(10'h02F, 8'h02);
        check("R5 closed write ldev", 32'(ldev_num), 0);

        // R2 / R3: key handling
        wr(10'h02E, 8'h83);
        check("R2 single key stays shut", 32'(cfg_mode), 0);
        wr(10'h02E, 8'h07);
        wr(10'h02E, 8'h83);
        check("R3 broken key stays shut", 32'(cfg_mode), 0);
        wr(10'h02E, 8'h83);
        check("R2 two keys open", 32'(cfg_mode), 1);
        getr(10'h02E, 8'h07, 8'h00, "R5 earlier closed write ignored");

        // R12
        rd(10'h02E, 8'hFF, "R12 index port read");

        // R7
        getr(10'h02E, 8'h20, 8'h71, "R7 id high");
        getr(10'h02E, 8'h21, 8'h20, "R7 id low");

        // R9
        setr(10'h02E, 8'h22, 8'h40);
        check("R9 pwr_on", 32'(pwr_on), 32'b010);
        setr(10'h02E, 8'h22, 8'hFF);
        getr(10'h02E, 8'h22, 8'hE0, "R9 pwr readback");
        setr(10'h02E, 8'h23, 8'hFF);
        check("R9 pme_en", 32'(pme_en), 32'hF);
        getr(10'h02E, 8'h23, 8'hF0, "R9 pme readback");

        // R10
        setr(10'h02E, 8'h02, 8'h01);
        check("R10 soft_rst pulse", 32'(soft_rst), 1);
        @(negedge clk);
        check("R10 soft_rst drops", 32'(soft_rst), 0);
        getr(10'h02E, 8'h02, 8'h00, "R10 srst reads 0");

        // R8: banked registers
        setr(10'h02E, 8'h07, 8'h01);
        setr(10'h02E, 8'h30, 8'hFF);
        setr(10'h02E, 8'h60, 8'h12);
        setr(10'h02E, 8'h61, 8'h34);
        setr(10'h02E, 8'h70, 8'h05);
        setr(10'h02E, 8'h74, 8'h0B);
        setr(10'h02E, 8'hF0, 8'h01);
        check("R8 active dev1", 32'(dev_active), 32'b010);
        check("R8 base dev1", 32'(dev_base[31:16]), 32'h1234);
        check("R8 irq dev1", 32'(dev_irq[7:4]), 32'h5);
        check("R8 drq dev1", 32'(dev_drq[7:4]), 32'hB);
        check("R8 opt dev1", 32'(dev_opt), 32'b010);
        getr(10'h02E, 8'h30, 8'h01, "R8 active readback");
        getr(10'h02E, 8'h60, 8'h12, "R8 base hi readback");
        setr(10'h02E, 8'h07, 8'h00);
        getr(10'h02E, 8'h60, 8'h00, "R8 dev0 separate");
        setr(10'h02E, 8'h07, 8'h02);
        setr(10'h02E, 8'h30, 8'h01);
        check("R8 active dev2", 32'(dev_active), 32'b110);
        setr(10'h02E, 8'h07, 8'h07);
        setr(10'h02E, 8'h30, 8'h00);
        check("R8 out-of-range write ignored", 32'(dev_active), 32'b110);
        getr(10'h02E, 8'h30, 8'h00, "R8 out-of-range reads 0");
        getr(10'h02E, 8'h20, 8'h71, "R9 global with any selector");

        // R6: port relocation
        setr(10'h02E, 8'h26, 8'h40);
        check("R6 port_sel", 32'(port_sel), 1);
        rd(10'h02F, 8'hFF, "R6 old data port ignored");
        rd(10'h04F, 8'h40, "R6 new data port");
        wr(10'h02E, 8'hAA);
        check("R6 old index port ignored", 32'(cfg_mode), 1);
        wr(10'h04E, 8'hAA);
        check("R4 exit key", 32'(cfg_mode), 0);
        rd(10'h04F, 8'hFF, "R4 closed after exit");
        enter(10'h02E);
        check("R6 keys at old pair ignored", 32'(cfg_mode), 0);
        enter(10'h04E);
        check("R6 keys at new pair", 32'(cfg_mode), 1);
        setr(10'h04E, 8'h26, 8'h00);
        check("R6 port back", 32'(port_sel), 0);

        // R11 with relocation in the same write
        setr(10'h02E, 8'h26, 8'h60);
        check("R11 locked", 32'(cfg_locked), 1);
        check("R11 mode shut", 32'(cfg_mode), 0);
        check("R6 moved with lock", 32'(port_sel), 1);
        enter(10'h04E);
        check("R11 keys ignored new pair", 32'(cfg_mode), 0);
        enter(10'h02E);
        check("R11 keys ignored old pair", 32'(cfg_mode), 0);
        rd(10'h04F, 8'hFF, "R11 locked read");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("R11 after hw reset");
        enter(10'h02E);
        check("R11 reopen after reset", 32'(cfg_mode), 1);

        repeat (3) @(negedge clk);
        check("scoreboard empty", 32'(q.size()), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule